// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Shift Port

This block moves one byte at a time over three wires: a serial data input, a serial data output and a shift clock. The byte is written into an 8-bit shift register through a parallel load. A start strobe then sends it out most-significant bit first. At the same time the bits arriving on the serial input are collected, so that after the transfer the register holds the received byte, which the parallel read returns.

The port has two clocking roles. As clock master it derives the shift clock from its own instruction-cycle clock. A 2-bit rate code selects a period of 2, 4 or 8 cycles, and the upper bit of the code takes priority. As clock follower it synchronises a shift clock driven from outside and counts its edges. In both roles the output bit changes on a falling shift-clock edge and the input bit is taken on a rising edge. The port works only while its enable input is high.

Top module: `sercom_port`

## Requirements
- R1: After reset, busy, done, sclk_out and sdo are 0, and rd_data is 0.
- R2: A start pulse with en=1, mode_master=1 and busy=0 raises busy on the next cycle. The port then drives exactly 8 high pulses on sclk_out. busy clears on the same edge that ends the eighth pulse. done is high for exactly one cycle, in the first cycle in which busy is 0, and sclk_out stays low whenever busy is 0.
- R3: The rate code is captured at start. Code 2'b00 gives a shift-clock period of 2 cycles and 2'b01 gives 4 cycles. Codes 2'b10 and 2'b11 both give 8 cycles, because bit 0 is ignored when bit 1 is set. A master transfer keeps busy high for 8 periods.
- R4: The byte is sent MSB first. Bit 7 of the register is on sdo from the start of the transfer, and sdo moves to the next bit only after a falling shift-clock edge.
- R5: sdi is taken on each rising shift-clock edge and enters the register at bit 0, moving the older bits towards bit 7. When done is reported, rd_data holds the 8 received bits, the first one received in bit 7.
- R6: With mode_master=0 the port passes sclk_in through a 2-stage synchroniser. It shifts on the synchronised edges, reports done after the eighth rising edge, and keeps sclk_out low.
- R7: While en=0 a start pulse is ignored and sclk_out stays low. Dropping en during a transfer clears busy and sclk_out on the next cycle, and no done is reported.
- R8: While busy=1, both a parallel load and a further start are ignored. The transmitted stream, the received byte and the transfer length are unchanged.
- R9: A load and a start in the same idle cycle both take effect: the freshly loaded byte is the one transmitted.
- R10: A load while idle places load_data in rd_data on the next cycle and puts load_data bit 7 on sdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable; 0 halts and idles the port |
| mode_master | input | 1 | 1: drive the shift clock; 0: follow sclk_in |
| rate_sel | input | 2 | Master shift-clock rate code |
| load | input | 1 | Parallel write strobe |
| load_data | input | 8 | Byte for the parallel write |
| start | input | 1 | Begin a byte transfer |
| sclk_in | input | 1 | External shift clock for follower mode |
| sdi | input | 1 | Serial data in |
| rd_data | output | 8 | Parallel read of the shift register |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated shift clock, low when idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a byte completes |

## Verification
A parallel write and a transfer start can land in the same clock cycle. The bench provokes this in two ways. First, it raises load and start together while idle, and judges the result by whether the new byte, not the old register contents, appears bit by bit on sdo. Second, it strikes load (or a second start) in the middle of a transfer, and judges that case by an unchanged outgoing stream, an unchanged received byte and an unchanged busy length. These collision cases are repeated across every rate code, next to plain transfers, follower-mode transfers and enable aborts.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  // Width of the half-period count of the master shift clock.
  localparam int HALF_W = 3;

  typedef enum logic [1:0] {
    RATE_P2  = 2'b00,
    RATE_P4  = 2'b01,
    RATE_P8  = 2'b10,
    RATE_P8X = 2'b11
  } rate_e;

  typedef enum logic {
    ROLE_FOLLOW = 1'b0,
    ROLE_DRIVE  = 1'b1
  } role_e;

  // Cycles per shift-clock half period; the upper code bit has priority.
  function automatic logic [HALF_W-1:0] half_len(input logic [1:0] code);
    logic [HALF_W-1:0] h;
    if (code[1])      h = HALF_W'(4);
    else if (code[0]) h = HALF_W'(2);
    else              h = HALF_W'(1);
    return h;
  endfunction

endpackage

// File: rtl/sercom_rate_gen.sv
module sercom_rate_gen #(
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == half - HW'(1));
  assign tick   = run & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/sercom_edge_sync.sv
module sercom_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/sercom_shifter.sv
module sercom_shifter #(
  parameter int WIDTH = 8,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             start,
  input  logic             rise,
  input  logic             fall,
  input  logic             sdi,
  output logic [WIDTH-1:0] data,
  output logic             sdo,
  output logic [CW-1:0]    cnt
);
  logic [WIDTH-1:0] sreg_q;
  logic             out_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg_q <= '0;
    else if (load) sreg_q <= load_val;
    else if (rise) sreg_q <= {sreg_q[WIDTH-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= 1'b0;
    else if (start) out_q <= load ? load_val[WIDTH-1] : sreg_q[WIDTH-1];
    else if (load)  out_q <= load_val[WIDTH-1];
    else if (fall)  out_q <= sreg_q[WIDTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (rise)  cnt_q <= cnt_q + CW'(1);
  end

  assign data = sreg_q;
  assign sdo  = out_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/sercom_port.sv
module sercom_port
  import sercom_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_master,
  input  logic [1:0]       rate_sel,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             start,
  input  logic             sclk_in,
  input  logic             sdi,
  output logic [WIDTH-1:0] rd_data,
  output logic             sdo,
  output logic             sclk_out,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic              busy_q, sclk_q, done_q;
  role_e             master_q;
  logic [HALF_W-1:0] half_q;

  // Named internal events, observed by the checker.
  logic              active, load_ok, start_go;
  logic              m_tick, m_rise, m_fall, s_rise, s_fall;
  logic              rise_ev, fall_ev, finish;
  logic [CNT_W-1:0]  bit_cnt;

  assign active   = busy_q & en;
  assign load_ok  = load & ~busy_q;
  assign start_go = en & start & ~busy_q;

  sercom_rate_gen #(.HW(HALF_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active & (master_q == ROLE_DRIVE)),
    .half (half_q),
    .tick (m_tick)
  );

  sercom_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sclk_in),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign m_rise  = m_tick & ~sclk_q;
  assign m_fall  = m_tick & sclk_q;
  assign rise_ev = active & ((master_q == ROLE_DRIVE) ? m_rise : s_rise);
  assign fall_ev = active & ((master_q == ROLE_DRIVE) ? m_fall : s_fall);
  assign finish  = (master_q == ROLE_DRIVE)
                 ? (fall_ev && bit_cnt == CNT_W'(WIDTH))
                 : (rise_ev && bit_cnt == CNT_W'(WIDTH - 1));

  sercom_shifter #(.WIDTH(WIDTH), .CW(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ok),
    .load_val(load_data),
    .start   (start_go),
    .rise    (rise_ev),
    .fall    (fall_ev),
    .sdi     (sdi),
    .data    (rd_data),
    .sdo     (sdo),
    .cnt     (bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      master_q <= ROLE_FOLLOW;
      half_q   <= HALF_W'(1);
    end else if (!en) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_go) begin
        busy_q   <= 1'b1;
        sclk_q   <= 1'b0;
        master_q <= role_e'(mode_master);
        half_q   <= half_len(rate_sel);
      end else if (finish) begin
        busy_q <= 1'b0;
        sclk_q <= 1'b0;
      end else if (m_tick) begin
        sclk_q <= ~sclk_q;
      end
    end
  end

  assign sclk_out = sclk_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/sercom_port_chk.sv
module sercom_port_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             load,
  input logic             busy,
  input logic             done,
  input logic             sclk_out,
  input logic             master_q,
  input logic             rise_ev,
  input logic [WIDTH-1:0] rd_data,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_out); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WIDTH)); // R2
  AST_FOLLOW_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !master_q) |-> !sclk_out); // R6
  AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !sclk_out)); // R7
  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !rise_ev) |=> $stable(rd_data)); // R8
endmodule

bind sercom_port sercom_port_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .load    (load),
  .busy    (busy),
  .done    (done),
  .sclk_out(sclk_out),
  .master_q(master_q),
  .rise_ev (rise_ev),
  .rd_data (rd_data),
  .bit_cnt (bit_cnt)
);

// File: tb/test_sercom_port.sv
module test_sercom_port;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode_master = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic load = 1'b0, start = 1'b0, sclk_in = 1'b0, sdi = 1'b0;
  logic [W-1:0] load_data = '0;
  logic [W-1:0] rd_data;
  logic sdo, sclk_out, busy, done;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  sercom_port #(.WIDTH(W)) i_sercom_port (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_master(mode_master),
    .rate_sel(rate_sel), .load(load), .load_data(load_data), .start(start),
    .sclk_in(sclk_in), .sdi(sdi), .rd_data(rd_data), .sdo(sdo),
    .sclk_out(sclk_out), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Period in cycles: doubles per code step, saturating at code 2.
  function automatic int period_of(input int code);
    int step;
    step = (code > 2) ? 2 : code;
    return 2 << step;
  endfunction

  // variant: 0 plain, 1 load mid-transfer, 2 start mid-transfer, 3 load+start together
  task automatic master_xfer(input int code, input logic [7:0] tx, input logic [7:0] peer,
                             input int variant);
    int cyc, pulses, dn;
    logic prev, did;
    logic [7:0] cap;
    string tg;
    tg = $sformatf("code=%0d v=%0d", code, variant);
    @(negedge clk);
    en = 1'b1; mode_master = 1'b1; rate_sel = code[1:0];
    load = 1'b1; load_data = (variant == 3) ? ~tx : tx;
    @(negedge clk);
    load = 1'b0;
    if (variant != 3) begin
      chk({"R10 rd_data after idle load ", tg}, int'(rd_data), int'(tx));
      chk({"R10 sdo after idle load ", tg}, int'(sdo), int'(tx[7]));
    end
    sdi = peer[7]; start = 1'b1;
    if (variant == 3) begin load = 1'b1; load_data = tx; end
    @(negedge clk);
    start = 1'b0; load = 1'b0;
    chk({"R2 busy after start ", tg}, int'(busy), 1);
    if (variant == 3) chk({"R9 first bit after joint load/start ", tg}, int'(sdo), int'(tx[7]));
    cyc = 0; pulses = 0; dn = 0; prev = 1'b0; did = 1'b0; cap = '0;
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      cyc++;
      if (done) dn++;
      if (sclk_out && !prev) begin
        cap = {cap[6:0], sdo};
        pulses++;
        if (pulses < 8) sdi = peer[7-pulses];
      end
      prev = sclk_out;
      load = 1'b0; start = 1'b0;
      if (pulses == 3 && !did && (variant == 1 || variant == 2)) begin
        did = 1'b1;
        if (variant == 1) begin load = 1'b1; load_data = ~tx; end
        else start = 1'b1;
      end
      @(negedge clk);
    end
    load = 1'b0; start = 1'b0;
    chk({"R2 done at end ", tg}, int'(done), 1);
    chk({"R2 clock idle low at end ", tg}, int'(sclk_out), 0);
    chk({"R2 no done while busy ", tg}, dn, 0);
    chk({(variant == 2) ? "R8 pulse count " : "R2 pulse count ", tg}, pulses, 8);
    chk({(variant == 2) ? "R8 busy length " : "R3 busy length ", tg}, cyc, 8 * period_of(code));
    chk({(variant == 1) ? "R8 stream " : (variant == 3) ? "R9 stream " : "R4 stream ", tg},
        int'(cap), int'(tx));
    chk({(variant == 1) ? "R8 received " : "R5 received ", tg}, int'(rd_data), int'(peer));
    @(negedge clk);
    chk({"R2 done one cycle ", tg}, int'(done), 0);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] peer);
    int dn, clk_seen;
    logic [7:0] cap;
    @(negedge clk);
    en = 1'b1; mode_master = 1'b0; sclk_in = 1'b0;
    load = 1'b1; load_data = tx;
    @(negedge clk);
    load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0; clk_seen = 0; cap = '0;
    for (int k = 0; k < 8; k++) begin
      sdi = peer[7-k];
      for (int j = 0; j < 4; j++) begin
        if (sclk_out) clk_seen++;
        if (done) dn++;
        @(negedge clk);
      end
      cap = {cap[6:0], sdo};
      chk($sformatf("R6 busy before rise %0d", k + 1), int'(busy), 1);
      sclk_in = 1'b1;
      for (int j = 0; j < 4; j++) begin
        if (sclk_out) clk_seen++;
        if (done) dn++;
        @(negedge clk);
      end
      sclk_in = 1'b0;
    end
    for (int j = 0; j < 4; j++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R6 follower done once", dn, 1);
    chk("R6 follower busy cleared", int'(busy), 0);
    chk("R6 follower sclk_out low", clk_seen, 0);
    chk("R4 follower stream", int'(cap), int'(tx));
    chk("R5 follower received", int'(rd_data), int'(peer));
  endtask

  initial begin
    #(20 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    int seen;
    pats = '{8'hA5, 8'h3C, 8'h01, 8'hFE, 8'h80};
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sclk_out", int'(sclk_out), 0);
    chk("R1 sdo", int'(sdo), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Disabled: start is ignored.
    en = 1'b0; mode_master = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy || sclk_out) seen++;
      @(negedge clk);
    end
    chk("R7 start ignored while disabled", seen, 0);

    // Sweep every rate code over several byte patterns.
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 5; p++)
        master_xfer(c, pats[p], {pats[(p + 2) % 5][3:0], pats[(p + 1) % 5][7:4]}, 0);

    // Collisions across all rate codes.
    for (int c = 0; c < 4; c++) begin
      master_xfer(c, 8'h5A, 8'hC3, 1);
      master_xfer(c, 8'h96, 8'h2D, 2);
      master_xfer(c, 8'hE1, 8'h78, 3);
    end

    // Follower mode.
    slave_xfer(8'hB4, 8'h69);
    slave_xfer(8'h0F, 8'hF0);

    // Abort by dropping the enable.
    @(negedge clk);
    en = 1'b1; mode_master = 1'b1; rate_sel = 2'b10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7 abort clears busy", int'(busy), 0);
    chk("R7 abort clock low", int'(sclk_out), 0);
    en = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (done || busy) seen++;
      @(negedge clk);
    end
    chk("R7 no done after abort", seen, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule